// File: doc/BRIEF.md
# SM4 Byte Substitution Unit over an AES S-box Core

This block returns the SM4 cipher's 8-bit substitution value for each input byte. It stores no SM4 table. Each byte first passes through an affine change of field, built from two 16-entry lookups: one indexed by the low nibble and one by the high nibble, with the two results XORed. The byte then goes through the plain AES forward SubBytes function. A second nibble-split affine map brings the result back into the SM4 field. There is no row shifting or column mixing anywhere in the path.

A lane-count parameter sets the datapath to one byte or to four bytes. Four lanes substitute a full 32-bit round word in one pass, each byte on its own and in its own position. A second parameter picks a purely combinational path or a single output register with asynchronous active-low reset. A third parameter chooses how the AES core is built: as GF(2^8) inversion followed by the AES affine step, or as a 256-entry constant ROM that is computed at elaboration.

Top module: `sm4sub_top`

## Requirements
- R1: Input byte 0x00 produces 0xD6 in every lane.
- R2: The output equals the standard SM4 S-box value. For example, 0x01→0x90, 0x10→0x2B, 0xF0→0x18 and 0xFF→0x48.
- R3: The map is a bijection: the 256 input values give 256 distinct outputs.
- R4: With four lanes, byte k of the output (bits 8k+7..8k) depends only on byte k of the input, and the byte order is preserved.
- R5: The pre-affine stage maps a nonzero byte to a value other than 0x01, which is the image of zero.
- R6: With the output register enabled, the output shows the substitution of the input sampled at the previous rising clock edge: exactly one cycle of latency.
- R7: With the output register enabled, the output is all zeros while reset is low.
- R8: With the output register disabled, the output follows the input within the same cycle, without waiting for a clock edge.
- R9: Both AES core styles, inversion-based and ROM-based, give identical results for all 256 inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_in | input | 8*LANES | Bytes to substitute, lane k in bits 8k+7..8k |
| sub_out | output | 8*LANES | Substituted bytes, same lane order |

## Verification
The all-zero word and a small set of known table entries, including the first and last rows of the table, pin down the absolute mapping. Placing a single known byte in each lane in turn, with zeros elsewhere, shows whether any lane is swapped or mixed with another. A full 256-value sweep with the same byte in all lanes proves the bijection. Over that sweep, the combinational ROM-style instance is compared against the registered inversion-style instance. A step from 0xFF to 0x00 with a mid-cycle sample separates a one-cycle register from a transparent path, and samples taken during reset show the cleared output.

// File: rtl/sm4sub_pkg.sv
`timescale 1ns/1ps
package sm4sub_pkg;

   typedef logic [7:0] byte_t;

   // Nibble tables of the field change into the AES field
   localparam byte_t PRE_LO [16] = '{
      8'h01, 8'h07, 8'h72, 8'h74, 8'hE4, 8'hE2, 8'h97, 8'h91,
      8'h57, 8'h51, 8'h24, 8'h22, 8'hB2, 8'hB4, 8'hC1, 8'hC7 };
   localparam byte_t PRE_HI [16] = '{
      8'h00, 8'hA2, 8'h49, 8'hEB, 8'h09, 8'hAB, 8'h40, 8'hE2,
      8'h12, 8'hB0, 8'h5B, 8'hF9, 8'h1B, 8'hB9, 8'h52, 8'hF0 };

   // Nibble tables of the field change back into the SM4 field
   localparam byte_t POST_LO [16] = '{
      8'h34, 8'h08, 8'h9D, 8'hA1, 8'hCE, 8'hF2, 8'h67, 8'h5B,
      8'h82, 8'hBE, 8'h2B, 8'h17, 8'h78, 8'h44, 8'hD1, 8'hED };
   localparam byte_t POST_HI [16] = '{
      8'h00, 8'hDC, 8'hAF, 8'h73, 8'hDD, 8'h01, 8'h72, 8'hAE,
      8'hBF, 8'h63, 8'h10, 8'hCC, 8'h62, 8'hBE, 8'hCD, 8'h11 };

   localparam byte_t AES_AFFINE_C = 8'h63;
   localparam byte_t AES_POLY_LO  = 8'h1B;

   function automatic byte_t rotl8(input byte_t x, input int unsigned n);
      return byte_t'((x << n) | (x >> (8 - n)));
   endfunction

   // Multiplication in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic byte_t gf_mul(input byte_t a, input byte_t b);
      byte_t acc;
      byte_t sh;
      acc = '0;
      sh  = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) acc = acc ^ sh;
         sh = sh[7] ? byte_t'((sh << 1) ^ AES_POLY_LO) : byte_t'(sh << 1);
      end
      return acc;
   endfunction

   // Inverse as a^254 (maps 0 to 0)
   function automatic byte_t gf_inv(input byte_t a);
      byte_t r;
      byte_t p;
      logic [7:0] e;
      r = 8'h01;
      p = a;
      e = 8'd254;
      for (int k = 0; k < 8; k++) begin
         if (e[k]) r = gf_mul(r, p);
         p = gf_mul(p, p);
      end
      return r;
   endfunction

   function automatic byte_t aes_fwd(input byte_t a);
      byte_t v;
      v = gf_inv(a);
      return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4)
             ^ AES_AFFINE_C;
   endfunction

endpackage

// File: rtl/sm4sub_nib_affine.sv
`timescale 1ns/1ps
module sm4sub_nib_affine
   import sm4sub_pkg::*;
#(
   parameter bit POST = 1'b0
) (
   input  byte_t a_i,
   output byte_t y_o
);
   localparam int unsigned NIB = 4;

   logic [NIB-1:0] lo_nib;
   logic [NIB-1:0] hi_nib;

   assign lo_nib = a_i[NIB-1:0];
   assign hi_nib = a_i[2*NIB-1:NIB];

   if (POST) begin : g_post
      assign y_o = POST_LO[lo_nib] ^ POST_HI[hi_nib];
   end else begin : g_pre
      assign y_o = PRE_LO[lo_nib] ^ PRE_HI[hi_nib];
   end

endmodule

// File: rtl/sm4sub_aes_sbox.sv
`timescale 1ns/1ps
module sm4sub_aes_sbox
   import sm4sub_pkg::*;
#(
   parameter int unsigned STYLE = 0
) (
   input  byte_t a_i,
   output byte_t y_o
);
   localparam int unsigned ROM_DEPTH = 256;

   if (STYLE == 0) begin : g_inv
      assign y_o = aes_fwd(a_i);
   end else if (STYLE == 1) begin : g_rom
      byte_t rom [ROM_DEPTH];
      for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_ent
         assign rom[g] = aes_fwd(byte_t'(g));
      end
      assign y_o = rom[a_i];
   end else begin : g_bad
      $error("sm4sub_aes_sbox: STYLE must be 0 or 1");
      assign y_o = '0;
   end

endmodule

// File: rtl/sm4sub_lane.sv
`timescale 1ns/1ps
module sm4sub_lane
   import sm4sub_pkg::*;
#(
   parameter int unsigned SBOX_STYLE = 0
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  byte_t byte_i,
   output byte_t byte_o
);
   byte_t to_aes;
   byte_t from_aes;

   sm4sub_nib_affine #(.POST(1'b0)) pre_i (
      .a_i (byte_i),
      .y_o (to_aes)
   );

   sm4sub_aes_sbox #(.STYLE(SBOX_STYLE)) core_i (
      .a_i (from_aes_src(to_aes)),
      .y_o (from_aes)
   );

   sm4sub_nib_affine #(.POST(1'b1)) post_i (
      .a_i (from_aes),
      .y_o (byte_o)
   );

   function automatic byte_t from_aes_src(input byte_t v);
      return v;
   endfunction

   assert_zero_byte_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_i == 8'h00) |-> (byte_o == 8'hD6));

   assert_last_entry_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_i == 8'hFF) |-> (byte_o == 8'h48));

   assert_pre_injective_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_i != 8'h00) |-> (to_aes != 8'h01));

endmodule

// File: rtl/sm4sub_top.sv
`timescale 1ns/1ps
module sm4sub_top
   import sm4sub_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter bit          OUT_REG    = 1'b1,
   parameter int unsigned SBOX_STYLE = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [LANES*8-1:0]   sub_in,
   output logic [LANES*8-1:0]   sub_out
);
   localparam int unsigned W = LANES * 8;

   if (!(LANES == 1 || LANES == 4)) begin : g_bad_lanes
      $error("sm4sub_top: LANES must be 1 or 4");
   end
   if (SBOX_STYLE > 1) begin : g_bad_style
      $error("sm4sub_top: SBOX_STYLE must be 0 or 1");
   end

   logic [W-1:0] sub_comb;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      sm4sub_lane #(.SBOX_STYLE(SBOX_STYLE)) lane_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .byte_i (sub_in[8*k +: 8]),
         .byte_o (sub_comb[8*k +: 8])
      );
   end

   if (OUT_REG) begin : g_reg
      logic [W-1:0] out_q;
      logic         armed_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            out_q   <= '0;
            armed_q <= 1'b0;
         end else begin
            out_q   <= sub_comb;
            armed_q <= 1'b1;
         end
      end
      assign sub_out = out_q;

      assert_one_cycle_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (armed_q && $past(sub_in[7:0]) == 8'h00) |-> (sub_out[7:0] == 8'hD6));
   end else begin : g_comb
      assign sub_out = sub_comb;
   end

   // Lane pairs: equal bytes give equal results, distinct bytes distinct ones
   for (genvar i = 0; i < LANES; i++) begin : g_pi
      for (genvar j = 0; j < LANES; j++) begin : g_pj
         if (j > i) begin : g_pair
            assert_lane_same_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
               (sub_in[8*i +: 8] == sub_in[8*j +: 8]) |->
               (sub_comb[8*i +: 8] == sub_comb[8*j +: 8]));
            assert_lane_distinct_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
               (sub_in[8*i +: 8] != sub_in[8*j +: 8]) |->
               (sub_comb[8*i +: 8] != sub_comb[8*j +: 8]));
         end
      end
   end

endmodule

// File: tb/sm4sub_top_tb_top.sv
`timescale 1ns/1ps
module sm4sub_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] din = '0;
   logic [31:0] dout;
   logic [7:0]  cin = '0;
   logic [7:0]  cout;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;
   bit          seen [256];

   // Known SM4 S-box entries: indices 0x00..0x1F, then 0xF0..0xFF
   localparam logic [7:0] KNOWN [48] = '{
      8'hD6, 8'h90, 8'hE9, 8'hFE, 8'hCC, 8'hE1, 8'h3D, 8'hB7,
      8'h16, 8'hB6, 8'h14, 8'hC2, 8'h28, 8'hFB, 8'h2C, 8'h05,
      8'h2B, 8'h67, 8'h9A, 8'h76, 8'h2A, 8'hBE, 8'h04, 8'hC3,
      8'hAA, 8'h44, 8'h13, 8'h26, 8'h49, 8'h86, 8'h06, 8'h99,
      8'h18, 8'hF0, 8'h7D, 8'hEC, 8'h3A, 8'hDC, 8'h4D, 8'h20,
      8'h79, 8'hEE, 8'h5F, 8'h3E, 8'hD7, 8'hCB, 8'h39, 8'h48 };

   always #2.5 clk = ~clk;

   sm4sub_top #(.LANES(4), .OUT_REG(1'b1), .SBOX_STYLE(0)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .sub_in (din), .sub_out (dout));

   sm4sub_top #(.LANES(1), .OUT_REG(1'b0), .SBOX_STYLE(1)) dut_comb_i (
      .clk_i (clk), .rst_ni (rst_n), .sub_in (cin), .sub_out (cout));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w);
      @(negedge clk);
      din = w;
      @(negedge clk);
   endtask

   task automatic t_reset_R7;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R7", dout, 32'h0);
      din = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R7", dout, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_zero_R1;
      apply(32'h0000_0000);
      check("R1", dout, 32'hD6D6_D6D6);
   endtask

   task automatic t_known_R2;
      for (int i = 0; i < 48; i++) begin
         logic [7:0]  idx;
         logic [31:0] exp;
         int unsigned sh;
         idx = (i < 32) ? 8'(i) : 8'(8'hF0 + i - 32);
         sh  = 8 * (i % 4);
         exp = (32'hD6D6_D6D6 & ~(32'hFF << sh)) | (32'(KNOWN[i]) << sh);
         apply(32'(idx) << sh);
         check("R2", dout, exp);
      end
   endtask

   task automatic t_order_R4;
      apply(32'h0010_FF01);
      check("R4", dout, 32'hD62B_4890);
      apply(32'hF001_1000);
      check("R4", dout, 32'h1890_2BD6);
   endtask

   task automatic t_latency_R6;
      apply(32'hFFFF_FFFF);
      check("R6", dout, 32'h4848_4848);
      @(negedge clk);
      din = 32'h0000_0000;
      #1;
      check("R6", dout, 32'h4848_4848);
      @(negedge clk);
      check("R6", dout, 32'hD6D6_D6D6);
   endtask

   task automatic t_comb_R8;
      @(negedge clk);
      cin = 8'h00;
      #0.5;
      check("R8", {24'h0, cout}, 32'hD6);
      cin = 8'hFF;
      #0.5;
      check("R8", {24'h0, cout}, 32'h48);
      cin = 8'h10;
      #0.5;
      check("R8", {24'h0, cout}, 32'h2B);
   endtask

   task automatic t_sweep_R3_R9;
      int unsigned distinct;
      for (int v = 0; v < 256; v++) seen[v] = 1'b0;
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         din = {4{8'(v)}};
         cin = 8'(v);
         @(negedge clk);
         check("R4", dout, {4{dout[7:0]}});
         check("R9", {24'h0, cout}, {24'h0, dout[7:0]});
         seen[dout[7:0]] = 1'b1;
      end
      distinct = 0;
      for (int v = 0; v < 256; v++) if (seen[v]) distinct++;
      check("R3", 32'(distinct), 32'd256);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_R7();
      t_zero_R1();
      t_known_R2();
      t_order_R4();
      t_latency_R6();
      t_comb_R8();
      t_sweep_R3_R9();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule